// File: doc/BRIEF.md
# VCO Band Search Sequencer

This controller chooses which of a VCO's discrete capacitor bands to use before the synthesizer loop is allowed to lock. Each time a new channel target is written, it parks the VCO tuning node at a fixed bias and starts the band code at zero. It then raises the band by one step per measurement. After each reference-period window, an external counting frequency comparator reports whether the VCO is still running slower than the target. As soon as the VCO is no longer slower, or the top band has been reached, the band code is frozen. Tuning is then handed back to the loop filter, and a power-down flag lets the search circuitry be shut off.

All logic runs on one fast system clock. Reference periods arrive as single-cycle `ref_tick` pulses. The comparator's down counter is controlled through a one-cycle reload pulse and a count-start level. A manual mode bypasses the search: the band code then steps on rising edges of a slow serial clock while a serial enable is high. Both serial lines are resynchronised inside the block. There is no data stream through this block, so every pin is a plain control or status level.

Top module: `vco_band_seeker`

## Requirements
- R1: After `rst_n` low, all outputs are 0: `band`, `ref_en`, `cmp_reload`, `cmp_start`, `vt_release` and `pwr_dn`.
- R2: With `man_mode` low, a `tgt_wr` pulse gives the following on the next cycle: `band`=0, `ref_en`=1, `cmp_start`=0, `vt_release`=0, `pwr_dn`=0.
- R3: After a launch, the first `ref_tick` makes `cmp_reload` high for exactly one cycle and sets `cmp_start` high, both on the next cycle.
- R4: A `ref_tick` while measuring with `cmp_slow`=1 and `band`<7 raises `band` by one. It also pulses `cmp_reload` and lowers `cmp_start`. The following `ref_tick` pulses `cmp_reload` again and raises `cmp_start`, so each band takes two reference ticks.
- R5: A `ref_tick` while measuring with `cmp_slow`=0 freezes the search. `band` holds, `ref_en` and `cmp_start` go to 0, and `vt_release` and `pwr_dn` go to 1.
- R6: When `band`=7 and `cmp_slow`=1 at a measuring tick, the search freezes at 7 rather than wrapping to 0.
- R7: A `tgt_wr` during a search restarts it from band 0, as in R2. If `tgt_wr` and a deciding `ref_tick` fall in the same cycle, the restart wins.
- R8: With `man_mode` high and `man_en` high, each rising edge of `man_clk` raises `band` by one, wrapping from 7 to 0, within 4 cycles. With `man_en` low, edges leave `band` unchanged.
- R9: With `man_mode` high, `ref_en`=0, `cmp_start`=0, `vt_release`=1 and `pwr_dn`=1. `tgt_wr` and `ref_tick` leave `band` unchanged.
- R10: A `bs_clear` pulse returns every output to its R1 value on the next cycle, even in mid-search. Later `ref_tick` pulses then start nothing.
- R11: A search freezes no later than the 16th `ref_tick` after launch. The count of ticks is exactly 2 + 2·(final band).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bs_clear | input | 1 | Synchronous clear of every register in the controller |
| tgt_wr | input | 1 | One-cycle strobe: a new channel target was written |
| ref_tick | input | 1 | One-cycle pulse marking each reference-period end |
| cmp_slow | input | 1 | Comparator verdict: 1 means the target count hit zero first (VCO still slow) |
| man_mode | input | 1 | 1 selects manual band stepping instead of the search |
| man_clk | input | 1 | Asynchronous serial clock; its rising edges step the band in manual mode |
| man_en | input | 1 | Asynchronous serial enable that qualifies manual steps |
| band | output | BAND_W | Band code driven to the VCO capacitor bank |
| ref_en | output | 1 | Enables the reference divider during a search |
| cmp_reload | output | 1 | One-cycle pulse that reloads the comparator counter with the target |
| cmp_start | output | 1 | Level that lets the comparator counter run for the current window |
| vt_release | output | 1 | 1 routes tuning to the loop filter; 0 holds the fixed bias |
| pwr_dn | output | 1 | 1 allows the search circuitry to be powered off |

## Verification
The case most likely to go wrong is a channel write landing in the very cycle in which a reference tick would otherwise decide the band. In that case a band increment (or a freeze) and a restart compete for the same registers. The bench lines up `tgt_wr` and `ref_tick` with `cmp_slow` high while the sequencer is measuring at band 1. It then expects band 0, an idle counter and a held bias on the next cycle, and the next tick must open a fresh measurement window. A second overlap occurs when a manual step edge arrives while a target write is presented in manual mode. The bench judges this by the band advancing only by the step and no search outputs appearing.

// File: rtl/vbs_pkg.sv
package vbs_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE = 3'd0,
    SQ_ARM  = 3'd1,
    SQ_MEAS = 3'd2,
    SQ_GAP  = 3'd3,
    SQ_DONE = 3'd4
  } seq_state_t;

  typedef struct packed {
    logic ref_en;
    logic cmp_start;
    logic cmp_reload;
    logic vt_release;
    logic pwr_dn;
  } seq_out_t;

  localparam seq_out_t SEQ_OUT_RESET = '{default: 1'b0};

endpackage

// File: rtl/vbs_man_step.sv
module vbs_man_step #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic ser_clk,
  input  logic ser_en,
  output logic step
);

  logic [STAGES-1:0] clk_chain;
  logic [STAGES-1:0] en_chain;
  logic              clk_prev;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_sync
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            clk_chain[0] <= 1'b0;
            en_chain[0]  <= 1'b0;
          end else if (clr) begin
            clk_chain[0] <= 1'b0;
            en_chain[0]  <= 1'b0;
          end else begin
            clk_chain[0] <= ser_clk;
            en_chain[0]  <= ser_en;
          end
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            clk_chain[s] <= 1'b0;
            en_chain[s]  <= 1'b0;
          end else if (clr) begin
            clk_chain[s] <= 1'b0;
            en_chain[s]  <= 1'b0;
          end else begin
            clk_chain[s] <= clk_chain[s-1];
            en_chain[s]  <= en_chain[s-1];
          end
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   clk_prev <= 1'b0;
    else if (clr) clk_prev <= 1'b0;
    else          clk_prev <= clk_chain[STAGES-1];
  end

  assign step = clk_chain[STAGES-1] & ~clk_prev & en_chain[STAGES-1];

endmodule

// File: rtl/vbs_band_reg.sv
module vbs_band_reg #(
  parameter int BAND_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              inc,
  output logic [BAND_W-1:0] band
);

  localparam logic [BAND_W-1:0] ONE = BAND_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    band <= '0;
    else if (clr)  band <= '0;
    else if (inc)  band <= band + ONE;
  end

endmodule

// File: rtl/vbs_seq.sv
module vbs_seq
  import vbs_pkg::*;
#(
  parameter int BAND_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              tgt_wr,
  input  logic              ref_tick,
  input  logic              cmp_slow,
  input  logic              man_mode,
  input  logic              man_step,
  input  logic [BAND_W-1:0] band,
  output logic              band_clr,
  output logic              band_inc,
  output seq_out_t          so
);

  localparam logic [BAND_W-1:0] TOP_BAND = {BAND_W{1'b1}};

  seq_state_t st;
  logic       at_top;
  logic       decide;
  logic       climb;

  assign at_top = (band == TOP_BAND);
  assign decide = !clr && !man_mode && !tgt_wr && (st == SQ_MEAS) && ref_tick;
  assign climb  = decide && cmp_slow && !at_top;

  assign band_clr = clr || (!man_mode && tgt_wr);
  assign band_inc = man_mode ? (man_step && !clr) : climb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= SQ_IDLE;
      so <= SEQ_OUT_RESET;
    end else if (clr) begin
      st <= SQ_IDLE;
      so <= SEQ_OUT_RESET;
    end else if (man_mode) begin
      st            <= SQ_DONE;
      so.ref_en     <= 1'b0;
      so.cmp_start  <= 1'b0;
      so.cmp_reload <= 1'b0;
      so.vt_release <= 1'b1;
      so.pwr_dn     <= 1'b1;
    end else if (tgt_wr) begin
      st            <= SQ_ARM;
      so.ref_en     <= 1'b1;
      so.cmp_start  <= 1'b0;
      so.cmp_reload <= 1'b0;
      so.vt_release <= 1'b0;
      so.pwr_dn     <= 1'b0;
    end else begin
      so.cmp_reload <= 1'b0;
      unique case (st)
        SQ_ARM, SQ_GAP: begin
          if (ref_tick) begin
            st            <= SQ_MEAS;
            so.cmp_reload <= 1'b1;
            so.cmp_start  <= 1'b1;
          end
        end
        SQ_MEAS: begin
          if (ref_tick) begin
            if (cmp_slow && !at_top) begin
              st            <= SQ_GAP;
              so.cmp_reload <= 1'b1;
              so.cmp_start  <= 1'b0;
            end else begin
              st            <= SQ_DONE;
              so.ref_en     <= 1'b0;
              so.cmp_start  <= 1'b0;
              so.vt_release <= 1'b1;
              so.pwr_dn     <= 1'b1;
            end
          end
        end
        default: begin
          st <= st;
        end
      endcase
    end
  end

endmodule

// File: rtl/vco_band_seeker.sv
module vco_band_seeker
  import vbs_pkg::*;
#(
  parameter int BAND_W      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bs_clear,
  input  logic              tgt_wr,
  input  logic              ref_tick,
  input  logic              cmp_slow,
  input  logic              man_mode,
  input  logic              man_clk,
  input  logic              man_en,
  output logic [BAND_W-1:0] band,
  output logic              ref_en,
  output logic              cmp_reload,
  output logic              cmp_start,
  output logic              vt_release,
  output logic              pwr_dn
);

  logic     man_step;
  logic     band_clr;
  logic     band_inc;
  seq_out_t so;

  vbs_man_step #(.STAGES(SYNC_STAGES)) u_step (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (bs_clear),
    .ser_clk (man_clk),
    .ser_en  (man_en),
    .step    (man_step)
  );

  vbs_seq #(.BAND_W(BAND_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (bs_clear),
    .tgt_wr   (tgt_wr),
    .ref_tick (ref_tick),
    .cmp_slow (cmp_slow),
    .man_mode (man_mode),
    .man_step (man_step),
    .band     (band),
    .band_clr (band_clr),
    .band_inc (band_inc),
    .so       (so)
  );

  vbs_band_reg #(.BAND_W(BAND_W)) u_band (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (band_clr),
    .inc   (band_inc),
    .band  (band)
  );

  assign ref_en     = so.ref_en;
  assign cmp_reload = so.cmp_reload;
  assign cmp_start  = so.cmp_start;
  assign vt_release = so.vt_release;
  assign pwr_dn     = so.pwr_dn;

endmodule

// File: rtl/vbs_checker.sv
module vbs_checker #(
  parameter int BAND_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bs_clear,
  input logic              tgt_wr,
  input logic              ref_tick,
  input logic              cmp_slow,
  input logic              man_mode,
  input logic              man_clk,
  input logic              man_en,
  input logic [BAND_W-1:0] band,
  input logic              ref_en,
  input logic              cmp_reload,
  input logic              cmp_start,
  input logic              vt_release,
  input logic              pwr_dn
);

  localparam logic [BAND_W-1:0] TOP_BAND = {BAND_W{1'b1}};

  assert_reload_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_reload |=> !cmp_reload);

  assert_auto_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!man_mode && !tgt_wr && !bs_clear && !ref_tick) |=> $stable(band));

  assert_frozen_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    vt_release |-> (!ref_en && !cmp_start));

  assert_top_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (band == TOP_BAND && !man_mode && !tgt_wr && !bs_clear) |=> band == TOP_BAND);

  assert_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_wr && !man_mode && !bs_clear) |=> (band == '0 && ref_en && !vt_release && !cmp_start));

  assert_manual_route_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (man_mode && !bs_clear) |=> (!ref_en && !cmp_start && vt_release && pwr_dn));

  assert_clear_all_R10: assert property (@(posedge clk) disable iff (!rst_n)
    bs_clear |=> (band == '0 && !ref_en && !cmp_start && !cmp_reload && !vt_release && !pwr_dn));

endmodule

bind vco_band_seeker vbs_checker #(.BAND_W(BAND_W)) u_chk (.*);

// File: tb/vco_band_seeker_test.sv
module vco_band_seeker_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bs_clear = 1'b0;
  logic       tgt_wr = 1'b0;
  logic       ref_tick = 1'b0;
  logic       cmp_slow = 1'b0;
  logic       man_mode = 1'b0;
  logic       man_clk = 1'b0;
  logic       man_en = 1'b0;
  logic [2:0] band;
  logic       ref_en, cmp_reload, cmp_start, vt_release, pwr_dn;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  vco_band_seeker uut (
    .clk(clk), .rst_n(rst_n), .bs_clear(bs_clear), .tgt_wr(tgt_wr),
    .ref_tick(ref_tick), .cmp_slow(cmp_slow), .man_mode(man_mode),
    .man_clk(man_clk), .man_en(man_en), .band(band), .ref_en(ref_en),
    .cmp_reload(cmp_reload), .cmp_start(cmp_start),
    .vt_release(vt_release), .pwr_dn(pwr_dn)
  );

  // {slow answers, expected final band, expected ticks to freeze}
  localparam logic [15:0] VEC [7] = '{
    {4'd0, 4'd0, 8'd2},  {4'd1, 4'd1, 8'd4},  {4'd3, 4'd3, 8'd8},
    {4'd5, 4'd5, 8'd12}, {4'd6, 4'd6, 8'd14}, {4'd7, 4'd7, 8'd16},
    {4'd9, 4'd7, 8'd16}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse_tgt();
    @(negedge clk) tgt_wr = 1'b1;
    @(negedge clk) tgt_wr = 1'b0;
  endtask

  task automatic pulse_tick();
    @(negedge clk) ref_tick = 1'b1;
    @(negedge clk) ref_tick = 1'b0;
  endtask

  task automatic man_edge();
    @(negedge clk) man_clk = 1'b1;
    repeat (4) @(negedge clk);
    man_clk = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic run_search(input int n, output int band_o, output int ticks);
    pulse_tgt();
    ticks = 0;
    pulse_tick(); ticks++;
    for (int k = 0; k < 20; k++) begin
      cmp_slow = (k < n);
      pulse_tick(); ticks++;
      if (vt_release) break;
      pulse_tick(); ticks++;
    end
    band_o = band;
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int b0, fb, tk;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 band", band, 0);
    chk("R1 ref_en", ref_en, 0);
    chk("R1 release", vt_release, 0);
    chk("R1 pwr_dn", pwr_dn, 0);
    chk("R1 start", cmp_start, 0);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);

    // table walk: R5, R6, R11
    foreach (VEC[i]) begin
      run_search(int'(VEC[i][15:12]), fb, tk);
      chk("R6 final band", fb, int'(VEC[i][11:8]));
      chk("R11 ticks", tk, int'(VEC[i][7:0]));
      chk("R5 release", vt_release, 1);
      chk("R5 pwr_dn", pwr_dn, 1);
      chk("R5 ref_en", ref_en, 0);
    end

    // R2, R3, R4 step-by-step
    pulse_tgt();
    chk("R2 band", band, 0);
    chk("R2 ref_en", ref_en, 1);
    chk("R2 release", vt_release, 0);
    chk("R2 pwr_dn", pwr_dn, 0);
    pulse_tick();
    chk("R3 reload", cmp_reload, 1);
    chk("R3 start", cmp_start, 1);
    @(negedge clk);
    chk("R3 reload one cycle", cmp_reload, 0);
    cmp_slow = 1'b1;
    pulse_tick();
    chk("R4 band", band, 1);
    chk("R4 reload", cmp_reload, 1);
    chk("R4 start low", cmp_start, 0);
    pulse_tick();
    chk("R4 band held in gap", band, 1);
    chk("R4 start again", cmp_start, 1);
    chk("R4 reload again", cmp_reload, 1);

    // R7 collision: restart and deciding tick in the same cycle
    @(negedge clk) begin tgt_wr = 1'b1; ref_tick = 1'b1; end
    @(negedge clk) begin tgt_wr = 1'b0; ref_tick = 1'b0; end
    chk("R7 band", band, 0);
    chk("R7 ref_en", ref_en, 1);
    chk("R7 start", cmp_start, 0);
    chk("R7 release", vt_release, 0);
    pulse_tick();
    chk("R7 new window", cmp_start, 1);
    pulse_tick();
    chk("R7 climbs", band, 1);

    // R10 dedicated clear mid-search
    pulse_tick();
    @(negedge clk) bs_clear = 1'b1;
    @(negedge clk) bs_clear = 1'b0;
    chk("R10 band", band, 0);
    chk("R10 ref_en", ref_en, 0);
    chk("R10 start", cmp_start, 0);
    chk("R10 release", vt_release, 0);
    pulse_tick();
    chk("R10 tick ignored start", cmp_start, 0);
    chk("R10 tick ignored band", band, 0);

    // R8, R9 manual mode
    @(negedge clk) man_mode = 1'b1;
    repeat (2) @(negedge clk);
    chk("R9 release", vt_release, 1);
    chk("R9 pwr_dn", pwr_dn, 1);
    chk("R9 ref_en", ref_en, 0);
    b0 = band;
    man_en = 1'b1;
    for (int i = 1; i <= 9; i++) begin
      man_edge();
      chk("R8 manual step", band, (b0 + i) % 8);
    end
    b0 = band;
    man_en = 1'b0;
    man_edge();
    chk("R8 enable low", band, b0);
    pulse_tgt();
    chk("R9 tgt ignored band", band, b0);
    chk("R9 tgt ignored ref_en", ref_en, 0);
    pulse_tick();
    chk("R9 tick ignored", band, b0);
    chk("R9 start", cmp_start, 0);
    @(negedge clk) man_mode = 1'b0;
    @(negedge clk);
    run_search(2, fb, tk);
    chk("R2 search after manual", fb, 2);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule